// File: doc/BRIEF.md
# Short-Vector Register Index Sequencer

This block drives the register-file addressing for one short-vector floating-point operation. It takes three split register specifiers (destination, first source, second source), a precision select, a vector length and a stride. When the configuration is legal, it emits one (destination, first source, second source) index triple per clock. Each index moves forward by the stride and wraps around inside its own register bank. A bank holds eight single-precision registers or four double-precision registers.

The block does not compute anything and holds no register data. A datapath next to it reads the sources at the emitted indices and writes the result at the emitted destination. When a configuration has no defined meaning, the block reports it on a one-cycle flag and emits nothing. A destination in a scalar bank turns the operation into a single scalar step. A second source in a scalar bank is reused for every element.

Top module: `vec_idx_seq`

## Requirements
- R1: Each 5-bit register index is decoded from a 4-bit field plus one extra bit. In double mode (`dbl_i`=1) the index is field + 16·bit. In single mode (`dbl_i`=0) it is 2·field + bit.
- R2: `len_i` encodes length−1, so lengths run 1 to 8. `stride_i`=0 means stride 1 and `stride_i`=1 means stride 2. When stride × length is greater than the bank size (8 in single mode, 4 in double mode), an accepted start pulses `unpred_o` for one cycle, one cycle after start. No element is emitted and `busy_o` stays low.
- R3: A start with length 1 and stride 2 is treated the same way as in R2: `unpred_o` pulses and no element is emitted.
- R4: A legal accepted start produces elements in consecutive cycles, beginning in the cycle after start. `elem_valid_o` is high for each element, and `elem_last_o` is high only on the final element. `busy_o` equals `elem_valid_o`.
- R5: From one element to the next, each advancing index becomes bank_base + ((index mod bank + stride) mod bank). An index never leaves its bank.
- R6: The scalar banks are single registers 0–7 and double registers 0–3 and 16–19. If the destination is in a scalar bank, exactly one element is emitted, whatever the length.
- R7: If the second source is in a scalar bank, its index keeps its decoded value on every element while the other two indices advance.
- R8: A start that arrives while `busy_o` is high is ignored. The running sequence continues unchanged and no second sequence follows it.
- R9: After reset, `busy_o`, `elem_valid_o`, `elem_last_o` and `unpred_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled when idle |
| dbl_i | input | 1 | 1 = double precision, 0 = single precision |
| d_field_i | input | 4 | Destination specifier field |
| d_ext_i | input | 1 | Destination extra bit |
| n_field_i | input | 4 | First source specifier field |
| n_ext_i | input | 1 | First source extra bit |
| m_field_i | input | 4 | Second source specifier field |
| m_ext_i | input | 1 | Second source extra bit |
| len_i | input | 3 | Vector length minus one |
| stride_i | input | 1 | 0 = stride 1, 1 = stride 2 |
| busy_o | output | 1 | Sequence in progress |
| elem_valid_o | output | 1 | Index triple valid this cycle |
| elem_last_o | output | 1 | Final element of the sequence |
| d_idx_o | output | 5 | Destination index |
| n_idx_o | output | 5 | First source index |
| m_idx_o | output | 5 | Second source index |
| unpred_o | output | 1 | Illegal configuration pulse |

## Verification
The bench starts from indices near the top of a bank with stride 2, so that a design that carried into the next bank, or wrapped modulo the whole file, would emit indices from the wrong bank. It tries every boundary of stride × length in both precisions. A comparison off by one would emit elements for an illegal configuration or flag a legal one. Destinations in the upper double scalar bank (16–19) catch a design that only tested the low bank. Such a design would emit a full vector where a single step is required. A start pulsed in the middle of a sequence exposes a design that restarts, or that queues a second sequence behind the first.

// File: rtl/vec_idx_pkg.sv
package vec_idx_pkg;
  localparam int FIELD_W   = 4;
  localparam int IDX_W     = FIELD_W + 1;
  localparam int LEN_W     = 3;
  localparam int SGL_OFF_W = 3;
  localparam int DBL_OFF_W = 2;
  localparam int SGL_BANK  = 1 << SGL_OFF_W;
  localparam int DBL_BANK  = 1 << DBL_OFF_W;

  typedef logic [IDX_W-1:0] idx_t;

  // True when the index lies in one of the scalar banks for the given precision.
  function automatic logic in_scalar_bank(idx_t idx, logic dbl);
    if (dbl) return (idx[IDX_W-2:DBL_OFF_W] == '0);
    else     return (idx[IDX_W-1:SGL_OFF_W] == '0);
  endfunction
endpackage

// File: rtl/vec_reg_decode.sv
module vec_reg_decode
  import vec_idx_pkg::*;
(
  input  logic [FIELD_W-1:0] field_i,
  input  logic               ext_i,
  input  logic               dbl_i,
  output idx_t               idx_o
);
  // double: extra bit is the top bit; single: extra bit is the bottom bit
  always_comb begin
    if (dbl_i) idx_o = {ext_i, field_i};
    else       idx_o = {field_i, ext_i};
  end
endmodule

// File: rtl/vec_bank_step.sv
module vec_bank_step
  import vec_idx_pkg::*;
(
  input  idx_t idx_i,
  input  logic dbl_i,
  input  logic stride_i,
  output idx_t idx_o
);
  logic [SGL_OFF_W-1:0] s_off;
  logic [DBL_OFF_W-1:0] d_off;

  always_comb begin
    s_off = idx_i[SGL_OFF_W-1:0] + (stride_i ? SGL_OFF_W'(2) : SGL_OFF_W'(1));
    d_off = idx_i[DBL_OFF_W-1:0] + (stride_i ? DBL_OFF_W'(2) : DBL_OFF_W'(1));
    if (dbl_i) idx_o = {idx_i[IDX_W-1:DBL_OFF_W], d_off};
    else       idx_o = {idx_i[IDX_W-1:SGL_OFF_W], s_off};
  end
endmodule

// File: rtl/vec_cfg_check.sv
module vec_cfg_check
  import vec_idx_pkg::*;
(
  input  logic             dbl_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             stride_i,
  output logic             illegal_o
);
  localparam int SPAN_W = LEN_W + 3;
  logic [SPAN_W-1:0] span;
  logic [SPAN_W-1:0] bank;

  always_comb begin
    span      = (SPAN_W'(len_i) + SPAN_W'(1)) << stride_i;
    bank      = dbl_i ? SPAN_W'(DBL_BANK) : SPAN_W'(SGL_BANK);
    illegal_o = (span > bank) || ((len_i == '0) && stride_i);
  end
endmodule

// File: rtl/vec_idx_seq.sv
module vec_idx_seq
  import vec_idx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               dbl_i,
  input  logic [FIELD_W-1:0] d_field_i,
  input  logic               d_ext_i,
  input  logic [FIELD_W-1:0] n_field_i,
  input  logic               n_ext_i,
  input  logic [FIELD_W-1:0] m_field_i,
  input  logic               m_ext_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic               stride_i,
  output logic               busy_o,
  output logic               elem_valid_o,
  output logic               elem_last_o,
  output logic [IDX_W-1:0]   d_idx_o,
  output logic [IDX_W-1:0]   n_idx_o,
  output logic [IDX_W-1:0]   m_idx_o,
  output logic               unpred_o
);
  localparam int NOPS = 3;

  logic [FIELD_W-1:0] fld [NOPS];
  logic               ext [NOPS];
  idx_t               dec [NOPS];
  idx_t               cur_q [NOPS];
  idx_t               cur_d [NOPS];
  idx_t               nxt [NOPS];

  logic             act_q, act_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic             dbl_q, dbl_d;
  logic             str_q, str_d;
  logic             mfix_q, mfix_d;
  logic             unp_q, unp_d;
  logic             illegal;
  logic             ld_en;

  assign fld[0] = d_field_i;  assign ext[0] = d_ext_i;
  assign fld[1] = n_field_i;  assign ext[1] = n_ext_i;
  assign fld[2] = m_field_i;  assign ext[2] = m_ext_i;

  genvar g;
  generate
    for (g = 0; g < NOPS; g++) begin : g_op
      vec_reg_decode u_dec (
        .field_i (fld[g]),
        .ext_i   (ext[g]),
        .dbl_i   (dbl_i),
        .idx_o   (dec[g])
      );
      vec_bank_step u_step (
        .idx_i    (cur_q[g]),
        .dbl_i    (dbl_q),
        .stride_i (str_q),
        .idx_o    (nxt[g])
      );
    end
  endgenerate

  vec_cfg_check u_chk (
    .dbl_i     (dbl_i),
    .len_i     (len_i),
    .stride_i  (stride_i),
    .illegal_o (illegal)
  );

  // next-state logic
  always_comb begin
    act_d  = act_q;
    rem_d  = rem_q;
    dbl_d  = dbl_q;
    str_d  = str_q;
    mfix_d = mfix_q;
    unp_d  = 1'b0;
    for (int i = 0; i < NOPS; i++) cur_d[i] = cur_q[i];
    if (act_q) begin
      if (rem_q == '0) begin
        act_d = 1'b0;
      end else begin
        rem_d    = rem_q - LEN_W'(1);
        cur_d[0] = nxt[0];
        cur_d[1] = nxt[1];
        if (!mfix_q) cur_d[2] = nxt[2];
      end
    end else if (start_i) begin
      if (illegal) begin
        unp_d = 1'b1;
      end else begin
        act_d  = 1'b1;
        dbl_d  = dbl_i;
        str_d  = stride_i;
        mfix_d = in_scalar_bank(dec[2], dbl_i);
        rem_d  = in_scalar_bank(dec[0], dbl_i) ? '0 : len_i;
        for (int i = 0; i < NOPS; i++) cur_d[i] = dec[i];
      end
    end
  end

  assign ld_en = act_q | start_i;

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      unp_q <= 1'b0;
    end else begin
      act_q <= act_d;
      unp_q <= unp_d;
    end
  end

  // datapath registers with explicit load enable
  always_ff @(posedge clk) begin
    if (ld_en) begin
      rem_q  <= rem_d;
      dbl_q  <= dbl_d;
      str_q  <= str_d;
      mfix_q <= mfix_d;
      for (int i = 0; i < NOPS; i++) cur_q[i] <= cur_d[i];
    end
  end

  assign busy_o       = act_q;
  assign elem_valid_o = act_q;
  assign elem_last_o  = act_q && (rem_q == '0);
  assign d_idx_o      = cur_q[0];
  assign n_idx_o      = cur_q[1];
  assign m_idx_o      = cur_q[2];
  assign unpred_o     = unp_q;

  // assertions
  assert_last_has_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    elem_last_o |-> elem_valid_o);

  assert_no_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_valid_o && !elem_last_o) |=> elem_valid_o);

  assert_unpred_no_elem_R2: assert property (@(posedge clk) disable iff (!rst_n)
    unpred_o |-> !elem_valid_o);

  assert_bank_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_valid_o && !elem_last_o) |=>
      (d_idx_o[IDX_W-1:SGL_OFF_W] == $past(d_idx_o[IDX_W-1:SGL_OFF_W])) &&
      (n_idx_o[IDX_W-1:SGL_OFF_W] == $past(n_idx_o[IDX_W-1:SGL_OFF_W])));

  assert_m_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_valid_o && !elem_last_o && mfix_q) |=> $stable(m_idx_o));

  assert_scalar_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_valid_o && in_scalar_bank(d_idx_o, dbl_q)) |-> elem_last_o);
endmodule

// File: tb/sim_vec_idx_seq.sv
module sim_vec_idx_seq;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i, dbl_i, d_ext_i, n_ext_i, m_ext_i, stride_i;
  logic [3:0] d_field_i, n_field_i, m_field_i;
  logic [2:0] len_i;
  logic       busy_o, elem_valid_o, elem_last_o, unpred_o;
  logic [4:0] d_idx_o, n_idx_o, m_idx_o;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_idx_seq u0 (
    .clk, .rst_n, .start_i, .dbl_i,
    .d_field_i, .d_ext_i, .n_field_i, .n_ext_i, .m_field_i, .m_ext_i,
    .len_i, .stride_i,
    .busy_o, .elem_valid_o, .elem_last_o,
    .d_idx_o, .n_idx_o, .m_idx_o, .unpred_o
  );

  function automatic logic [4:0] m_dec(logic [3:0] f, logic e, logic dbl);
    return dbl ? 5'(f) + (e ? 5'd16 : 5'd0) : 5'(2 * f) + 5'(e);
  endfunction

  function automatic logic [4:0] m_step(logic [4:0] idx, logic dbl, logic s);
    int bank = dbl ? 4 : 8;
    int base = idx - (idx % bank);
    return 5'(base + ((idx % bank) + (s ? 2 : 1)) % bank);
  endfunction

  function automatic logic m_scalar(logic [4:0] idx, logic dbl);
    return dbl ? (idx < 4 || (idx >= 16 && idx < 20)) : (idx < 8);
  endfunction

  function automatic logic m_illegal(logic dbl, logic [2:0] l, logic s);
    int span = (int'(l) + 1) * (s ? 2 : 1);
    return (span > (dbl ? 4 : 8)) || (l == 0 && s);
  endfunction

  task automatic check(logic ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_op(logic dbl, logic [3:0] df, logic de, logic [3:0] nf, logic ne,
                        logic [3:0] mf, logic me, logic [2:0] l, logic s,
                        logic poke, string req);
    logic [4:0] ed, en, em;
    logic       mfix;
    int         eff;
    @(negedge clk);
    dbl_i = dbl; d_field_i = df; d_ext_i = de; n_field_i = nf; n_ext_i = ne;
    m_field_i = mf; m_ext_i = me; len_i = l; stride_i = s; start_i = 1'b1;
    ed = m_dec(df, de, dbl); en = m_dec(nf, ne, dbl); em = m_dec(mf, me, dbl);
    mfix = m_scalar(em, dbl);
    eff  = m_scalar(ed, dbl) ? 1 : int'(l) + 1;
    @(negedge clk);
    start_i = 1'b0;
    if (m_illegal(dbl, l, s)) begin
      check(unpred_o && !elem_valid_o && !busy_o, req, "unpred pulse",
            {unpred_o, elem_valid_o}, 2);
      @(negedge clk);
      check(!unpred_o && !elem_valid_o, req, "no elements after unpred",
            {unpred_o, elem_valid_o}, 0);
      return;
    end
    for (int k = 0; k < eff; k++) begin
      check(elem_valid_o && busy_o && !unpred_o, req, "valid", elem_valid_o, 1);
      check(elem_last_o == (k == eff - 1), req, "last flag", elem_last_o, k == eff - 1);
      check(d_idx_o == ed && n_idx_o == en && m_idx_o == em, req, "indices d/n/m",
            {d_idx_o, n_idx_o, m_idx_o}, {ed, en, em});
      ed = m_step(ed, dbl, s);
      en = m_step(en, dbl, s);
      if (!mfix) em = m_step(em, dbl, s);
      if (poke && k == 0) begin
        // R8: a start while busy, with a legal and different configuration
        start_i = 1'b1; dbl_i = ~dbl; d_field_i = 4'd9; len_i = 3'd0; stride_i = 1'b0;
      end
      @(negedge clk);
      start_i = 1'b0;
    end
    check(!elem_valid_o && !busy_o, req, "idle after last", elem_valid_o, 0);
    if (poke) begin
      @(negedge clk);
      check(!elem_valid_o && !unpred_o, "R8", "no queued sequence", elem_valid_o, 0);
    end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    start_i = 0; dbl_i = 0; d_ext_i = 0; n_ext_i = 0; m_ext_i = 0; stride_i = 0;
    d_field_i = 0; n_field_i = 0; m_field_i = 0; len_i = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy_o && !elem_valid_o && !elem_last_o && !unpred_o, "R9", "reset state",
          {busy_o, elem_valid_o, elem_last_o, unpred_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !unpred_o, "R9", "idle after release", busy_o, 0);

    // R1: decode, double field 5 ext 1 -> 21, single field 5 ext 1 -> 11
    run_op(1, 4'd5, 1, 4'd6, 1, 4'd7, 1, 3'd0, 0, 0, "R1");
    run_op(0, 4'd5, 1, 4'd6, 0, 4'd12, 1, 3'd0, 0, 0, "R1");
    // R5: wrap at bank top, single stride 2 length 4 from index 14
    run_op(0, 4'd7, 0, 4'd15, 1, 4'd13, 0, 3'd3, 1, 0, "R5");
    // R5: double stride 1 length 4 from D7 (bank 4..7) and D30
    run_op(1, 4'd7, 0, 4'd14, 1, 4'd10, 0, 3'd3, 0, 0, "R5");
    // R2: boundaries of stride x length
    run_op(0, 4'd8, 0, 4'd8, 0, 4'd8, 0, 3'd4, 1, 0, "R2");
    run_op(1, 4'd8, 0, 4'd8, 0, 4'd8, 0, 3'd4, 0, 0, "R2");
    run_op(1, 4'd8, 0, 4'd8, 0, 4'd8, 0, 3'd2, 1, 0, "R2");
    run_op(1, 4'd8, 0, 4'd9, 0, 4'd10, 0, 3'd1, 1, 0, "R2");
    run_op(0, 4'd8, 0, 4'd9, 0, 4'd10, 0, 3'd7, 0, 0, "R4");
    // R3: length 1 stride 2
    run_op(0, 4'd8, 0, 4'd8, 0, 4'd8, 0, 3'd0, 1, 0, "R3");
    // R6: destination in scalar banks, including D16..D19
    run_op(1, 4'd2, 1, 4'd8, 0, 4'd9, 0, 3'd3, 0, 0, "R6");
    run_op(0, 4'd3, 0, 4'd8, 0, 4'd9, 0, 3'd7, 0, 0, "R6");
    // R7: second operand in a scalar bank stays fixed
    run_op(0, 4'd8, 1, 4'd12, 0, 4'd1, 1, 3'd5, 0, 0, "R7");
    run_op(1, 4'd4, 0, 4'd8, 1, 4'd3, 1, 3'd3, 0, 0, "R7");
    // R8: start while busy is ignored
    run_op(0, 4'd4, 0, 4'd6, 0, 4'd10, 0, 3'd3, 1, 1, "R8");

    void'($urandom(32'd1234));
    for (int t = 0; t < 300; t++) begin
      run_op(1'($urandom), 4'($urandom), 1'($urandom), 4'($urandom), 1'($urandom),
             4'($urandom), 1'($urandom), 3'($urandom), 1'($urandom), 0, "R4/R5");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule